// File: doc/BRIEF.md
# Even/Odd Dual-Issue Pairing Stage

This block is the in-order issue stage of a core with two execution pipes, called even and odd. Each cycle it sees the two oldest fetched instructions, slot 0 (older) and slot 1 (younger). For each it receives the least-significant bit of the word address, a decoded operation class, a destination register with an enable, and up to three source registers, each with an enable. It decides whether to issue nothing, issue slot 0 alone, or issue both. It reports which pipes receive an instruction and how many instructions were consumed. The fetch side shifts its queue by that count.

A pair issues together only when two things hold. The two instructions must be independent of each other. Their address parities must also fit their pipes: the older one sits at an even word and goes to the even pipe, and the younger one sits at an odd word and goes to the odd pipe. In every other case they issue one after the other. A countdown scoreboard covers all entries of the shared register file. It stalls slot 0 while any register it reads or writes is still waiting for a result. An issued instruction loads its destination's counter from its class latency. The scoreboard changes only at issue and as time passes.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset no register is pending, so a valid non-NOP instruction in slot 0 issues in the first cycle whatever registers it names.
- R2: Nothing issues while slot 0 is not valid, and slot 1 never issues unless slot 0 issues in the same cycle.
- R3: Both slots issue (`iss_count` = 2, both pipe valids high) only if slot 0 has address bit 0 and an even-pipe class, slot 1 has address bit 1 and an odd-pipe class, and both are otherwise ready.
- R4: A pair is split when slot 1 reads slot 0's destination or writes the same destination. Slot 1 writing a register that slot 0 only reads does not split it.
- R5: Class codes select the pipe and the latency. Even-pipe classes are 1 simple integer/logic/compare/select (2), 2 byte sum/difference/average (4), 3 even shift/rotate (4), 4 floating point (6) and 5 integer multiply-accumulate (7). Odd-pipe classes are 6 shuffle/quadword rotate/estimate (4), 7 load/store (6), 8 channel (6) and 9 branch (1). Code 0 is NOP. Codes 10 to 15 act as class 1. An instruction issued alone raises only the valid of its class's pipe.
- R6: An instruction that reads a register written by an instruction issued in cycle t with latency L issues no earlier than cycle t+L. It issues in cycle t+L if nothing else holds it.
- R7: An instruction whose enabled destination is still pending stalls until that register is free.
- R8: A NOP (class 0) skips all scoreboard and independence checks and never marks a register pending. It uses the pipe given by its own address bit: 0 is even, 1 is odd.
- R9: `iss_count` is 0, 1 or 2. When it is 1, exactly one pipe valid is high. When it is 0, neither is high.
- R10: A source whose enable bit is clear never causes a stall, even when it names a pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_waddr_lsb | input | 1 | Bit 0 of slot 0 word address |
| s0_cls | input | 4 | Slot 0 operation class |
| s0_dst | input | 7 | Slot 0 destination register |
| s0_dst_en | input | 1 | Slot 0 writes a register |
| s0_srcs | input | 21 | Slot 0 sources, source i at bits [7i+6:7i] |
| s0_src_en | input | 3 | Slot 0 source enables, bit i for source i |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_waddr_lsb | input | 1 | Bit 0 of slot 1 word address |
| s1_cls | input | 4 | Slot 1 operation class |
| s1_dst | input | 7 | Slot 1 destination register |
| s1_dst_en | input | 1 | Slot 1 writes a register |
| s1_srcs | input | 21 | Slot 1 sources, same packing as slot 0 |
| s1_src_en | input | 3 | Slot 1 source enables |
| iss_even | output | 1 | An instruction goes to the even pipe this cycle |
| iss_odd | output | 1 | An instruction goes to the odd pipe this cycle |
| iss_count | output | 2 | Instructions consumed this cycle |

## Verification
Some rules hold cycle by cycle, and the assertions check these on every cycle. A pair always has the right parity-to-pipe shape and no dependence between its two halves. An issuing slot 0 never names a pending register. An issued writer leaves its destination pending in the next cycle. The pipe valids agree with the count. Other properties show only across a sequence of cycles, so only the bench scenarios can show them. These are the exact issue cycle after each class's latency, the fact that NOPs leave no trace in the scoreboard, that a write-after-read pair still dual-issues, and that disabled sources have no effect. The bench checks them against a timestamp model of register readiness.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int CNT_W = 3;  // holds latency-1 for the longest class (7)

  typedef enum logic [3:0] {
    CL_NOP  = 4'd0,
    CL_INT  = 4'd1,
    CL_BYTE = 4'd2,
    CL_SHR  = 4'd3,
    CL_FP   = 4'd4,
    CL_MAC  = 4'd5,
    CL_PERM = 4'd6,
    CL_LDST = 4'd7,
    CL_CHAN = 4'd8,
    CL_BR   = 4'd9
  } op_cls_e;

  function automatic logic cls_is_odd(input logic [3:0] c);
    return (c == CL_PERM) || (c == CL_LDST) || (c == CL_CHAN) || (c == CL_BR);
  endfunction

  function automatic logic [CNT_W:0] cls_latency(input logic [3:0] c);
    case (c)
      CL_BYTE, CL_SHR, CL_PERM: return 4'd4;
      CL_FP, CL_LDST, CL_CHAN:  return 4'd6;
      CL_MAC:                   return 4'd7;
      CL_BR:                    return 4'd1;
      default:                  return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/dip_scoreboard.sv
module dip_scoreboard #(
  parameter int NREG  = 128,
  parameter int REG_W = 7,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w0_en,
  input  logic [REG_W-1:0] w0_idx,
  input  logic [CW-1:0]    w0_cnt,
  input  logic             w1_en,
  input  logic [REG_W-1:0] w1_idx,
  input  logic [CW-1:0]    w1_cnt,
  output logic [NREG-1:0]  busy
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_ce;

    always_comb begin
      cnt_ce = 1'b0;
      cnt_d  = cnt_q;
      if (w0_en && (w0_idx == REG_W'(g))) begin
        cnt_ce = 1'b1;
        cnt_d  = w0_cnt;
      end else if (w1_en && (w1_idx == REG_W'(g))) begin
        cnt_ce = 1'b1;
        cnt_d  = w1_cnt;
      end else if (cnt_q != '0) begin
        cnt_ce = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
    end

    assign busy[g] = (cnt_q != '0);
  end

endmodule

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int NREG  = 128,
  parameter int REG_W = 7,
  parameter int NSRC  = 3
) (
  input  logic [NREG-1:0]       busy,
  input  logic [NSRC*REG_W-1:0] srcs,
  input  logic [NSRC-1:0]       src_en,
  input  logic [REG_W-1:0]      dst,
  input  logic                  dst_en,
  output logic                  clear
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_en[i] && busy[srcs[i*REG_W +: REG_W]]) hit = 1'b1;
    end
    if (dst_en && busy[dst]) hit = 1'b1;
    clear = !hit;
  end

endmodule

// File: rtl/dip_pair.sv
module dip_pair #(
  parameter int REG_W = 7,
  parameter int NSRC  = 3
) (
  input  logic                  v0,
  input  logic                  v1,
  input  logic                  par0,
  input  logic                  par1,
  input  logic                  odd0,
  input  logic                  odd1,
  input  logic [REG_W-1:0]      dst0,
  input  logic                  dst0_en,
  input  logic [NSRC*REG_W-1:0] srcs1,
  input  logic [NSRC-1:0]       src1_en,
  input  logic [REG_W-1:0]      dst1,
  input  logic                  dst1_en,
  input  logic                  clr0,
  input  logic                  clr1,
  output logic                  take0,
  output logic                  take1,
  output logic                  go_even,
  output logic                  go_odd,
  output logic [1:0]            cnt
);

  logic raw;
  logic waw;
  logic shape_ok;

  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src1_en[i] && dst0_en && (srcs1[i*REG_W +: REG_W] == dst0)) raw = 1'b1;
    end
    waw      = dst0_en && dst1_en && (dst0 == dst1);
    shape_ok = !par0 && !odd0 && par1 && odd1;
    take0    = v0 && clr0;
    take1    = take0 && v1 && shape_ok && !raw && !waw && clr1;
    go_even  = take1 || (take0 && !odd0);
    go_odd   = take1 || (take0 && odd0);
    cnt      = {take1, take0 && !take1};
  end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter  int NREG  = 128,
  parameter  int NSRC  = 3,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s0_valid,
  input  logic                  s0_waddr_lsb,
  input  logic [3:0]            s0_cls,
  input  logic [REG_W-1:0]      s0_dst,
  input  logic                  s0_dst_en,
  input  logic [NSRC*REG_W-1:0] s0_srcs,
  input  logic [NSRC-1:0]       s0_src_en,
  input  logic                  s1_valid,
  input  logic                  s1_waddr_lsb,
  input  logic [3:0]            s1_cls,
  input  logic [REG_W-1:0]      s1_dst,
  input  logic                  s1_dst_en,
  input  logic [NSRC*REG_W-1:0] s1_srcs,
  input  logic [NSRC-1:0]       s1_src_en,
  output logic                  iss_even,
  output logic                  iss_odd,
  output logic [1:0]            iss_count
);

  logic            nop0, nop1;
  logic            odd0, odd1;
  logic            den0, den1;
  logic [NSRC-1:0] sen0, sen1;
  logic            clr0, clr1;
  logic            take0, take1;
  logic [CNT_W:0]  lat0, lat1;
  logic [NREG-1:0] busy;

  // A NOP names no registers and follows its own address parity.
  always_comb begin
    nop0 = (s0_cls == CL_NOP);
    nop1 = (s1_cls == CL_NOP);
    odd0 = nop0 ? s0_waddr_lsb : cls_is_odd(s0_cls);
    odd1 = nop1 ? s1_waddr_lsb : cls_is_odd(s1_cls);
    den0 = s0_dst_en && !nop0;
    den1 = s1_dst_en && !nop1;
    sen0 = nop0 ? '0 : s0_src_en;
    sen1 = nop1 ? '0 : s1_src_en;
    lat0 = cls_latency(s0_cls) - 1'b1;
    lat1 = cls_latency(s1_cls) - 1'b1;
  end

  dip_hazard #(.NREG(NREG), .REG_W(REG_W), .NSRC(NSRC)) u_haz0 (
    .busy(busy), .srcs(s0_srcs), .src_en(sen0),
    .dst(s0_dst), .dst_en(den0), .clear(clr0)
  );

  dip_hazard #(.NREG(NREG), .REG_W(REG_W), .NSRC(NSRC)) u_haz1 (
    .busy(busy), .srcs(s1_srcs), .src_en(sen1),
    .dst(s1_dst), .dst_en(den1), .clear(clr1)
  );

  dip_pair #(.REG_W(REG_W), .NSRC(NSRC)) u_pair (
    .v0(s0_valid), .v1(s1_valid),
    .par0(s0_waddr_lsb), .par1(s1_waddr_lsb),
    .odd0(odd0), .odd1(odd1),
    .dst0(s0_dst), .dst0_en(den0),
    .srcs1(s1_srcs), .src1_en(sen1),
    .dst1(s1_dst), .dst1_en(den1),
    .clr0(clr0), .clr1(clr1),
    .take0(take0), .take1(take1),
    .go_even(iss_even), .go_odd(iss_odd), .cnt(iss_count)
  );

  dip_scoreboard #(.NREG(NREG), .REG_W(REG_W), .CW(CNT_W)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .w0_en(take0 && den0), .w0_idx(s0_dst), .w0_cnt(lat0[CNT_W-1:0]),
    .w1_en(take1 && den1), .w1_idx(s1_dst), .w1_cnt(lat1[CNT_W-1:0]),
    .busy(busy)
  );

endmodule

// File: rtl/dip_checker.sv
module dip_checker
  import dip_pkg::*;
#(
  parameter  int NREG  = 128,
  parameter  int NSRC  = 3,
  localparam int REG_W = $clog2(NREG)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  s0_valid,
  input logic                  s0_waddr_lsb,
  input logic [3:0]            s0_cls,
  input logic [REG_W-1:0]      s0_dst,
  input logic                  s0_dst_en,
  input logic [NSRC*REG_W-1:0] s0_srcs,
  input logic [NSRC-1:0]       s0_src_en,
  input logic                  s1_waddr_lsb,
  input logic [3:0]            s1_cls,
  input logic [NSRC*REG_W-1:0] s1_srcs,
  input logic [NSRC-1:0]       s1_src_en,
  input logic                  iss_even,
  input logic                  iss_odd,
  input logic [1:0]            iss_count,
  input logic [NREG-1:0]       busy
);

  logic w0, pair_raw, src_busy;

  always_comb begin
    w0       = s0_dst_en && (s0_cls != CL_NOP);
    pair_raw = 1'b0;
    src_busy = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (w0 && (s1_cls != CL_NOP) && s1_src_en[i] &&
          (s1_srcs[i*REG_W +: REG_W] == s0_dst)) pair_raw = 1'b1;
      if ((s0_cls != CL_NOP) && s0_src_en[i] &&
          busy[s0_srcs[i*REG_W +: REG_W]]) src_busy = 1'b1;
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_valid |-> (iss_count == 2'd0) && !iss_even && !iss_odd);

  assert_pair_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_count == 2'd2) |-> !s0_waddr_lsb && s1_waddr_lsb && iss_even && iss_odd);

  assert_pair_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_count == 2'd2) |-> !pair_raw);

  assert_src_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_count != 2'd0) |-> !src_busy);

  assert_pending_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_count != 2'd0) && w0 && (cls_latency(s0_cls) > 4'd1)) |=> busy[$past(s0_dst)]);

  assert_dst_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_count != 2'd0) && w0) |-> !busy[s0_dst]);

  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_count != 2'd3) && ((iss_count == 2'd1) -> (iss_even ^ iss_odd)));

endmodule

bind dual_issue_pair dip_checker #(.NREG(NREG), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s0_valid(s0_valid), .s0_waddr_lsb(s0_waddr_lsb), .s0_cls(s0_cls),
  .s0_dst(s0_dst), .s0_dst_en(s0_dst_en), .s0_srcs(s0_srcs), .s0_src_en(s0_src_en),
  .s1_waddr_lsb(s1_waddr_lsb), .s1_cls(s1_cls),
  .s1_srcs(s1_srcs), .s1_src_en(s1_src_en),
  .iss_even(iss_even), .iss_odd(iss_odd), .iss_count(iss_count),
  .busy(busy)
);

// File: tb/tb_dual_issue_pair.sv
module tb_dual_issue_pair;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int b_v[2], b_par[2], b_cls[2], b_dst[2], b_den[2], b_sen[2];
  int b_src[2][3];

  logic       iss_even, iss_odd;
  logic [1:0] iss_count;

  dual_issue_pair dut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(b_v[0] != 0), .s0_waddr_lsb(b_par[0] != 0), .s0_cls(4'(b_cls[0])),
    .s0_dst(RW'(b_dst[0])), .s0_dst_en(b_den[0] != 0),
    .s0_srcs({RW'(b_src[0][2]), RW'(b_src[0][1]), RW'(b_src[0][0])}),
    .s0_src_en(3'(b_sen[0])),
    .s1_valid(b_v[1] != 0), .s1_waddr_lsb(b_par[1] != 0), .s1_cls(4'(b_cls[1])),
    .s1_dst(RW'(b_dst[1])), .s1_dst_en(b_den[1] != 0),
    .s1_srcs({RW'(b_src[1][2]), RW'(b_src[1][1]), RW'(b_src[1][0])}),
    .s1_src_en(3'(b_sen[1])),
    .iss_even(iss_even), .iss_odd(iss_odd), .iss_count(iss_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rdy[128];
  int last_cnt;
  bit done = 0;

  // R5 table as stated in the requirements
  function automatic bit cls_odd(int c);
    return (c >= 6) && (c <= 9);
  endfunction

  function automatic int cls_lat(int c);
    case (c)
      2, 3, 6: return 4;
      4, 7, 8: return 6;
      5:       return 7;
      9:       return 1;
      default: return 2;
    endcase
  endfunction

  function automatic bit slot_ok(int k);
    if (b_cls[k] == 0) return 1;
    for (int i = 0; i < 3; i++)
      if (b_sen[k][i] && rdy[b_src[k][i]] > cyc) return 0;
    if (b_den[k] != 0 && rdy[b_dst[k]] > cyc) return 0;
    return 1;
  endfunction

  function automatic bit slot_odd(int k);
    return (b_cls[k] == 0) ? (b_par[k] != 0) : cls_odd(b_cls[k]);
  endfunction

  function automatic int exp_count();
    bit t0, dep;
    t0 = (b_v[0] != 0) && slot_ok(0);
    if (!t0) return 0;
    dep = 0;
    if (b_cls[0] != 0 && b_den[0] != 0 && b_cls[1] != 0) begin
      for (int i = 0; i < 3; i++)
        if (b_sen[1][i] && b_src[1][i] == b_dst[0]) dep = 1;
      if (b_den[1] != 0 && b_dst[1] == b_dst[0]) dep = 1;
    end
    if ((b_v[1] != 0) && b_par[0] == 0 && !slot_odd(0) && b_par[1] != 0 &&
        slot_odd(1) && !dep && slot_ok(1)) return 2;
    return 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_slot(int k, int v, int par, int c, int d, int den,
                          int a, int b, int e, int sen);
    b_v[k] = v; b_par[k] = par; b_cls[k] = c; b_dst[k] = d; b_den[k] = den;
    b_src[k][0] = a; b_src[k][1] = b; b_src[k][2] = e; b_sen[k] = sen;
  endtask

  // Called at a negedge with inputs set; checks and advances one cycle.
  task automatic step(string tag);
    int ec;
    bit ee, eo;
    #1;
    ec = exp_count();
    ee = (ec == 2) || (ec == 1 && !slot_odd(0));
    eo = (ec == 2) || (ec == 1 && slot_odd(0));
    chk(tag, "count", int'(iss_count), ec);
    chk(tag, "even", int'(iss_even), int'(ee));
    chk(tag, "odd", int'(iss_odd), int'(eo));
    last_cnt = int'(iss_count);
    @(posedge clk);
    if (ec >= 1 && b_cls[0] != 0 && b_den[0] != 0) rdy[b_dst[0]] = cyc + cls_lat(b_cls[0]);
    if (ec == 2 && b_cls[1] != 0 && b_den[1] != 0) rdy[b_dst[1]] = cyc + cls_lat(b_cls[1]);
    cyc++;
    @(negedge clk);
  endtask

  task automatic drain();
    set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R2");
  endtask

  task automatic lat_probe(int c);
    int n;
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_slot(0, 1, 1, c, 10, 1, 0, 0, 0, 0);
    step("R5");
    set_slot(0, 1, 1, 1, 11, 0, 10, 0, 0, 1);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      n++;
      step("R6");
      if (last_cnt != 0) break;
    end
    chk("R6", $sformatf("issue distance cls%0d", c), n, cls_lat(c));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int r = 0; r < 128; r++) rdy[r] = 0;
    set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: clean scoreboard after reset
    set_slot(0, 1, 0, 1, 4, 1, 1, 2, 3, 7);
    step("R1");
    chk("R1", "first issue", last_cnt, 1);
    drain();

    // R2: slot 1 alone never issues
    set_slot(1, 1, 1, 7, 5, 1, 0, 0, 0, 0);
    step("R2");
    chk("R2", "slot1 alone", last_cnt, 0);
    drain();

    // R5 / R6: pipe and latency of each class
    for (int c = 1; c <= 9; c++) lat_probe(c);
    drain();

    // R3: good pair, bad parity, swapped pipes
    set_slot(0, 1, 0, 1, 20, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 7, 21, 1, 0, 0, 0, 0);
    step("R3");
    chk("R3", "pair", last_cnt, 2);
    drain();
    set_slot(0, 1, 1, 1, 22, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 7, 23, 1, 0, 0, 0, 0);
    step("R3");
    chk("R3", "odd first address", last_cnt, 1);
    drain();
    set_slot(0, 1, 0, 6, 24, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 1, 25, 1, 0, 0, 0, 0);
    step("R3");
    chk("R3", "swapped pipes", last_cnt, 1);
    drain();

    // R4: RAW and WAW split, WAR pairs
    set_slot(0, 1, 0, 1, 30, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 7, 31, 1, 0, 30, 0, 2);
    step("R4");
    chk("R4", "raw in pair", last_cnt, 1);
    drain();
    set_slot(0, 1, 0, 1, 32, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 7, 32, 1, 0, 0, 0, 0);
    step("R4");
    chk("R4", "waw in pair", last_cnt, 1);
    drain();
    set_slot(0, 1, 0, 1, 33, 1, 34, 0, 0, 1);
    set_slot(1, 1, 1, 7, 34, 1, 0, 0, 0, 0);
    step("R4");
    chk("R4", "war in pair", last_cnt, 2);
    drain();

    // R7: pending destination stalls
    set_slot(0, 1, 1, 4, 40, 1, 0, 0, 0, 0);
    step("R7");
    set_slot(0, 1, 1, 1, 40, 1, 0, 0, 0, 0);
    step("R7");
    chk("R7", "waw stall", last_cnt, 0);
    drain();

    // R8: NOP ignores scoreboard, routes by parity, marks nothing
    set_slot(0, 1, 1, 5, 50, 1, 0, 0, 0, 0);
    step("R8");
    set_slot(0, 1, 1, 0, 50, 1, 50, 50, 50, 7);
    step("R8");
    chk("R8", "nop past busy reg", last_cnt, 1);
    set_slot(0, 1, 0, 0, 51, 1, 0, 0, 0, 0);
    set_slot(1, 1, 1, 7, 52, 1, 0, 0, 0, 0);
    step("R8");
    chk("R8", "nop pairs", last_cnt, 2);
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_slot(0, 1, 1, 1, 53, 0, 51, 0, 0, 1);
    step("R8");
    chk("R8", "nop left no pending", last_cnt, 1);
    drain();

    // R10: disabled source on a busy register
    set_slot(0, 1, 1, 7, 60, 1, 0, 0, 0, 0);
    step("R10");
    set_slot(0, 1, 1, 1, 61, 1, 60, 60, 60, 0);
    step("R10");
    chk("R10", "masked source", last_cnt, 1);
    drain();

    // R9 and mixed traffic: random with a small register window
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 2; k++)
        set_slot(k, ($urandom % 10) != 0, $urandom % 2, $urandom % 10,
                 $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 8,
                 $urandom % 8, $urandom % 8);
      step("R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule